// File: doc/BRIEF.md
# SPI Slave Shift Engine

This block is the serial side of an SPI slave. It takes the bus clock, the active-low select and the master-out line, and it drives the slave-out line. Three mode inputs set how it works: clock polarity, clock phase and bit order. A fourth input picks a transfer width of 8 or 16 bits. The parallel side has a transmit load port, a receive data register and a transfer-complete flag. A read of the receive register clears the flag.

All three bus inputs pass through two-flop synchronisers into the system clock domain. Bus clock edges are detected and numbered in that domain. The bus clock must run at no more than a quarter of the system clock. Polarity is removed from the bus clock before edges are numbered, so edge 1 is always the first edge away from the idle level. Each received bit is held in a one-bit latch on one class of edge and moved into the shared shift register on the other class. The transmit word leaves from the same register. When the last shift edge of a word arrives, the received word is copied to the receive register and the flag is raised.

Top module: `spi_slave_engine`

## Requirements
- R1: In phase 0 (`cpha_i`=0), edges 1, 3, 5, ... store the `mosi_i` level in the hold latch. Edges 2, 4, 6, ... shift that stored bit into the word. A phase-0 transfer therefore returns the word the master sent.
- R2: In phase 1 (`cpha_i`=1), edges 2, 4, 6, ... store `mosi_i`. Edges 3, 5, ... shift the stored bit in. The final edge shifts in the bit present at that edge. A phase-1 transfer returns the word the master sent.
- R3: With `lsb_first_i`=1, bit 0 is the first bit on both lines and received bits enter at the top of the word. With `lsb_first_i`=0, the most significant bit goes first (bit 15 when wide, bit 7 when narrow).
- R4: In phase 0, the first transmit bit is on `miso_o` once select is low, before any bus clock edge. Each later bit appears after edges 2, 4, 6, ...
- R5: In phase 1, `miso_o` is 0 from select falling until edge 1. After edge 1 it shows the first bit, and each later bit appears after edges 3, 5, ...
- R6: After the final edge of a word, `rx_data_o` holds the received word and `spif_o` is 1. Reset clears both to 0.
- R7: A transfer ends on edge 16 when `wide_i`=0 and on edge 32 when `wide_i`=1. In narrow mode, bits 15:8 of `rx_data_o` are 0.
- R8: While select is high, `miso_oe_o` is 0. Bus clock edges are ignored: `spif_o` and `rx_data_o` do not change.
- R9: If select rises before the final edge, the edge count is cleared, `spif_o` is not set and `rx_data_o` keeps its value. The next transfer starts again at edge 1 with the loaded word.
- R10: A one-cycle pulse on `rx_read_i` clears `spif_o`. A transfer that completes while `spif_o` is already 1 overwrites `rx_data_o` and leaves the flag set.
- R11: With `cpol_i`=1, the bus clock idles high and edge 1 is a falling edge. Otherwise the transfer behaves exactly as with `cpol_i`=0.
- R12: `miso_oe_o` changes on the second rising system clock edge after `ss_ni` changes. Other results are due by the third rising edge after the bus clock pin changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpol_i | input | 1 | Bus clock idle level |
| cpha_i | input | 1 | Clock phase select |
| lsb_first_i | input | 1 | 1: least significant bit first |
| wide_i | input | 1 | 1: 16-bit words, 0: 8-bit words |
| tx_load_i | input | 1 | Write strobe for the transmit word |
| tx_data_i | input | 16 | Transmit word |
| rx_read_i | input | 1 | Receive register read strobe; clears the flag |
| sck_i | input | 1 | Bus clock from the master |
| ss_ni | input | 1 | Slave select, active low |
| mosi_i | input | 1 | Serial data from the master |
| miso_o | output | 1 | Serial data to the master |
| miso_oe_o | output | 1 | Output enable for `miso_o` |
| rx_data_o | output | 16 | Last completed received word |
| spif_o | output | 1 | Transfer-complete flag |

## Verification
Every bus pin change reaches the logic after two synchroniser flops and one register. So `miso_o`, `rx_data_o` and `spif_o` settle by the third rising system clock edge after the change. `miso_oe_o` settles by the second. The bench drives pins on falling system clock edges and holds each bus clock level for four system cycles. It samples `miso_o` just before the next bus clock edge and checks the flag and receive word four cycles after the last edge. The select-to-enable path is sampled one cycle before and one cycle after its due edge, which pins the latency exactly.

// File: rtl/spi_slv_pkg.sv
package spi_slv_pkg;
  localparam int unsigned MAX_W    = 16;
  localparam int unsigned NARROW_W = 8;
  localparam int unsigned CNT_W    = $clog2(2 * MAX_W);
  localparam int unsigned SYNC_N   = 2;

  typedef logic [MAX_W-1:0] word_t;
  typedef logic [CNT_W-1:0] cnt_t;
endpackage

// File: rtl/spi_slv_sync.sv
module spi_slv_sync #(
  parameter int unsigned           WIDTH   = 1,
  parameter int unsigned           STAGES  = 2,
  parameter logic [WIDTH-1:0]      RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[g] <= RST_VAL;
      else if (g == 0) stg_q[g] <= d_i;
      else stg_q[g] <= stg_q[(g == 0) ? 0 : g-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/spi_slv_edge.sv
module spi_slv_edge
  import spi_slv_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_s_i,
  input  logic ss_s_i,
  input  logic cpol_i,
  input  logic cpha_i,
  input  logic wide_i,
  output logic latch_o,
  output logic shift_o,
  output logic last_o,
  output logic done_o,
  output logic ss_fall_o,
  output cnt_t cnt_o
);
  logic sck_n, sck_q, ss_q, edge_v, odd;
  cnt_t cnt_q, last_cnt;

  assign sck_n    = sck_s_i ^ cpol_i;  // normalised: idle low
  assign edge_v   = (sck_n ^ sck_q) & ~ss_s_i;
  assign odd      = ~cnt_q[0];         // edge number = cnt_q + 1
  assign last_cnt = wide_i ? cnt_t'(2*MAX_W-1) : cnt_t'(2*NARROW_W-1);
  assign last_o   = edge_v & (cnt_q == last_cnt);
  assign ss_fall_o = ss_q & ~ss_s_i;

  always_comb begin
    if (cpha_i) begin
      latch_o = edge_v & ~odd;
      shift_o = edge_v & ((odd & (cnt_q != '0)) | last_o);
    end else begin
      latch_o = edge_v & odd;
      shift_o = edge_v & ~odd;
    end
  end

  assign done_o = last_o;
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q <= 1'b0;
      ss_q  <= 1'b1;
      cnt_q <= '0;
    end else begin
      sck_q <= sck_n;
      ss_q  <= ss_s_i;
      if (ss_s_i)      cnt_q <= '0;
      else if (last_o) cnt_q <= '0;
      else if (edge_v) cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_NARROW_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wide_i && !ss_s_i) |-> cnt_q < cnt_t'(2*NARROW_W)); // R7
  AST_EDGE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_v && !last_o) |=> cnt_q == $past(cnt_q) + 1'b1); // R7
  AST_LATCH_SHIFT_SPLIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(latch_o && shift_o && !last_o)); // R1
endmodule

// File: rtl/spi_slv_shift.sv
module spi_slv_shift
  import spi_slv_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  lsb_first_i,
  input  logic  wide_i,
  input  logic  cpha_i,
  input  logic  mosi_s_i,
  input  logic  latch_i,
  input  logic  shift_i,
  input  logic  last_i,
  input  logic  load_i,
  input  word_t load_data_i,
  output logic  tx_bit_o,
  output word_t rx_word_o
);
  word_t sh_q, sh_r, sh_l, nxt, mask;
  logic  hold_q, in_bit;
  int    top;

  assign top    = wide_i ? MAX_W-1 : NARROW_W-1;
  assign mask   = wide_i ? '1 : word_t'((1 << NARROW_W) - 1);
  assign in_bit = (cpha_i & last_i) ? mosi_s_i : hold_q;
  assign sh_r   = {1'b0, sh_q[MAX_W-1:1]};
  assign sh_l   = {sh_q[MAX_W-2:0], 1'b0};

  always_comb begin
    for (int i = 0; i < MAX_W; i++) begin
      if (lsb_first_i) nxt[i] = (i == top) ? in_bit : ((i < top) ? sh_r[i] : 1'b0);
      else             nxt[i] = (i == 0)   ? in_bit : ((i <= top) ? sh_l[i] : 1'b0);
    end
  end

  assign tx_bit_o  = lsb_first_i ? sh_q[0] : (wide_i ? sh_q[MAX_W-1] : sh_q[NARROW_W-1]);
  assign rx_word_o = nxt & mask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      hold_q <= 1'b0;
    end else begin
      if (latch_i) hold_q <= mosi_s_i;
      if (load_i)       sh_q <= load_data_i & mask;
      else if (shift_i) sh_q <= nxt;
    end
  end

  AST_NARROW_TOP_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wide_i && $past(!wide_i) && $past(shift_i || load_i)) |-> sh_q[MAX_W-1:NARROW_W] == '0); // R7
endmodule

// File: rtl/spi_slave_engine.sv
module spi_slave_engine
  import spi_slv_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpol_i,
  input  logic              cpha_i,
  input  logic              lsb_first_i,
  input  logic              wide_i,
  input  logic              tx_load_i,
  input  logic [MAX_W-1:0]  tx_data_i,
  input  logic              rx_read_i,
  input  logic              sck_i,
  input  logic              ss_ni,
  input  logic              mosi_i,
  output logic              miso_o,
  output logic              miso_oe_o,
  output logic [MAX_W-1:0]  rx_data_o,
  output logic              spif_o
);
  logic  sck_s, ss_s, mosi_s;
  logic  latch, shift, last, done, ss_fall, tx_bit;
  cnt_t  cnt;
  word_t tx_buf_q, rx_q, rx_word;
  logic  spif_q;

  spi_slv_sync #(.WIDTH(3), .STAGES(SYNC_N), .RST_VAL(3'b010)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({sck_i, ss_ni, mosi_i}),
    .q_o    ({sck_s, ss_s, mosi_s})
  );

  spi_slv_edge u_edge (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sck_s_i   (sck_s),
    .ss_s_i    (ss_s),
    .cpol_i    (cpol_i),
    .cpha_i    (cpha_i),
    .wide_i    (wide_i),
    .latch_o   (latch),
    .shift_o   (shift),
    .last_o    (last),
    .done_o    (done),
    .ss_fall_o (ss_fall),
    .cnt_o     (cnt)
  );

  spi_slv_shift u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .lsb_first_i (lsb_first_i),
    .wide_i      (wide_i),
    .cpha_i      (cpha_i),
    .mosi_s_i    (mosi_s),
    .latch_i     (latch),
    .shift_i     (shift),
    .last_i      (last),
    .load_i      (ss_fall | done),
    .load_data_i (tx_buf_q),
    .tx_bit_o    (tx_bit),
    .rx_word_o   (rx_word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_buf_q <= '0;
      rx_q     <= '0;
      spif_q   <= 1'b0;
    end else begin
      if (tx_load_i) tx_buf_q <= tx_data_i;
      if (done) rx_q <= rx_word;
      if (done)           spif_q <= 1'b1;  // completion wins over read
      else if (rx_read_i) spif_q <= 1'b0;
    end
  end

  assign miso_oe_o = ~ss_s;
  assign miso_o    = (ss_s | (cpha_i & (cnt == '0))) ? 1'b0 : tx_bit;
  assign rx_data_o = rx_q;
  assign spif_o    = spif_q;

  AST_FLAG_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(spif_q) |-> $past(done)); // R6
  AST_READ_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_read_i && !done) |=> !spif_q); // R10
  AST_RX_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done |=> $stable(rx_q)); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ss_s |=> !spif_q || $past(spif_q)); // R8
endmodule

// File: tb/tb_spi_slave_engine.sv
module tb_spi_slave_engine;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cpol = 0, cpha = 0, lsb = 0, wide = 0, tx_load = 0, rx_read = 0;
  logic sck = 0, ss_n = 1, mosi = 0;
  logic [15:0] tx_data = '0;
  logic miso, miso_oe, spif;
  logic [15:0] rx_data;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;  // 125 MHz

  spi_slave_engine dut (
    .clk_i(clk), .rst_ni(rst_n), .cpol_i(cpol), .cpha_i(cpha),
    .lsb_first_i(lsb), .wide_i(wide), .tx_load_i(tx_load), .tx_data_i(tx_data),
    .rx_read_i(rx_read), .sck_i(sck), .ss_ni(ss_n), .mosi_i(mosi),
    .miso_o(miso), .miso_oe_o(miso_oe), .rx_data_o(rx_data), .spif_o(spif)
  );

  // {cpol, cpha, lsb_first, wide, tx word, mosi word}
  localparam logic [35:0] VEC [8] = '{
    {4'b0000, 16'h00A5, 16'h003C},
    {4'b0001, 16'hC3A1, 16'h5E72},
    {4'b0100, 16'h0096, 16'h00E1},
    {4'b0111, 16'h1234, 16'hFEDC},
    {4'b1000, 16'h005A, 16'h00C7},
    {4'b1011, 16'h8001, 16'h7FFE},
    {4'b1101, 16'h6B2D, 16'h9C4F},
    {4'b1110, 16'h00F0, 16'h0081}
  };

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic bus_edge();
    sck = ~sck;
    ticks(4);
  endtask

  task automatic setup(input logic [3:0] m, input logic [15:0] tx);
    {cpol, cpha, lsb, wide} = m;
    sck = m[3];
    tx_data = tx; tx_load = 1;
    ticks(1);
    tx_load = 0;
    ticks(4);
  endtask

  task automatic pulse_read();
    rx_read = 1;
    ticks(1);
    rx_read = 0;
    ticks(1);
  endtask

  // full transfer; checks MISO bit stream and the completion result
  task automatic xfer(input logic [3:0] m, input logic [15:0] tx, input logic [15:0] mo);
    int n = m[0] ? 16 : 8;
    string mtag = m[1] ? "R3" : (m[3] ? "R11" : (m[2] ? "R2" : "R1"));
    string rtag = !m[0] ? "R7" : (m[2] ? "R2" : "R1");
    setup(m, tx);
    ss_n = 0;
    if (!cpha) mosi = mo[lsb ? 0 : n-1];
    ticks(4);
    if (!cpha) begin
      chk("R4", {15'b0, miso}, {15'b0, tx[lsb ? 0 : n-1]});
      for (int k = 0; k < n; k++) begin
        bus_edge();
        bus_edge();
        if (k < n-1) begin
          chk(mtag, {15'b0, miso}, {15'b0, tx[lsb ? k+1 : n-2-k]});
          mosi = mo[lsb ? k+1 : n-2-k];
        end
      end
    end else begin
      chk("R5", {15'b0, miso}, 16'h0);
      for (int k = 0; k < n; k++) begin
        bus_edge();
        chk(k == 0 ? "R5" : mtag, {15'b0, miso}, {15'b0, tx[lsb ? k : n-1-k]});
        mosi = mo[lsb ? k : n-1-k];
        bus_edge();
      end
    end
    chk("R6", {15'b0, spif}, 16'h1);
    chk(rtag, rx_data, m[0] ? mo : {8'h00, mo[7:0]});
    ss_n = 1;
    ticks(4);
  endtask

  initial begin
    ticks(3);
    chk("R6", {15'b0, spif}, 16'h0);
    chk("R6", rx_data, 16'h0);
    chk("R8", {15'b0, miso_oe}, 16'h0);
    rst_n = 1;
    ticks(3);

    // table walk
    for (int i = 0; i < 8; i++) begin
      xfer(VEC[i][35:32], VEC[i][31:16], VEC[i][15:0]);
      chk("R8", {15'b0, miso_oe}, 16'h0);
      pulse_read();
      chk("R10", {15'b0, spif}, 16'h0);
    end

    // R8: bus clock toggling while deselected changes nothing
    setup(4'b0001, 16'hAAAA);
    for (int k = 0; k < 40; k++) begin sck = ~sck; ticks(3); end
    chk("R8", {15'b0, spif}, 16'h0);
    chk("R8", rx_data, {8'h00, VEC[7][7:0]});

    // R9: abort after 5 edges, then a clean transfer
    setup(4'b0000, 16'h00C3);
    ss_n = 0; mosi = 1; ticks(4);
    for (int k = 0; k < 5; k++) bus_edge();
    ss_n = 1; ticks(6);
    chk("R9", {15'b0, spif}, 16'h0);
    chk("R9", rx_data, {8'h00, VEC[7][7:0]});
    xfer(4'b0000, 16'h00C3, 16'h0069);

    // R10: second completion overwrites while flag still set
    xfer(4'b0001, 16'h0F0F, 16'hBEEF);
    chk("R10", {15'b0, spif}, 16'h1);
    chk("R10", rx_data, 16'hBEEF);
    pulse_read();
    chk("R10", {15'b0, spif}, 16'h0);

    // R12: enable latency from select
    ss_n = 0;
    @(negedge clk);
    chk("R12", {15'b0, miso_oe}, 16'h0);
    @(negedge clk);
    chk("R12", {15'b0, miso_oe}, 16'h1);
    ss_n = 1;
    @(negedge clk);
    chk("R12", {15'b0, miso_oe}, 16'h1);
    @(negedge clk);
    chk("R12", {15'b0, miso_oe}, 16'h0);

    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog act=%h exp=%h", 16'h0, 16'h1);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule